// File: doc/BRIEF.md
# Packet-Filter Arithmetic Execute Unit

This block is the arithmetic stage of a small 64-bit packet-filter processor. Each instruction reaches it as an opcode byte together with the destination register value, the source register value and a 32-bit immediate. It returns the value to be written back, a write strobe and an illegal-instruction flag. Register access, fetch, branches and memory operations happen elsewhere.

The opcode byte has three fields. Bits [2:0] give the class: 0x4 is the 32-bit arithmetic class and 0x7 is the 64-bit one. Bit 3 picks the second operand: 0 for the source register, 1 for the immediate. Bits [7:4] give the operation. The datapath is combinational. Its outputs are registered, so each result appears one clock after the instruction is presented.

Top module: `pf_alu`

## Requirements
- R1: In class 0x7 (64-bit), op codes perform full 64-bit operations: 0x0 add, 0x1 subtract, 0x4 OR, 0x5 AND, 0xa XOR and 0xb move (result = second operand). Each such result is written with wr_en=1 and illegal=0.
- R2: Opcode bit 3 = 0 takes the source register as the second operand. Bit 3 = 1 takes the immediate instead, sign-extended to 64 bits in class 0x7.
- R3: In class 0x4 (32-bit), the operation works on the low 32 bits of each operand. The immediate is used as is, and the 32-bit result is zero-extended to 64 bits.
- R4: Op 0x6 shifts left, op 0x7 shifts right filling with zeros, and op 0xc shifts right filling with the sign bit of the operand width. The shift amount is the low 5 bits of the second operand in class 0x4 and the low 6 bits in class 0x7.
- R5: Op 0x2 returns the low bits of the unsigned product at the width of the class.
- R6: Op 0x3 is an unsigned divide and op 0x9 an unsigned remainder. Dividing by zero gives 0. A remainder by zero returns the destination value, truncated to 32 bits in class 0x4.
- R7: Op 0x8 returns the two's-complement negation of the destination value at the width of the class.
- R8: Op 0xd converts byte order in either class. An immediate of 16, 32 or 64 sets the width. Bit 3 = 0 (little-endian) keeps the low bytes of that width unchanged. Bit 3 = 1 (big-endian) reverses the order of those bytes. Either way the result is zero-extended.
- R9: An instruction is illegal if its op code is 0xe or 0xf, its class is anything other than 0x4 or 0x7, or it is op 0xd with an immediate other than 16, 32 or 64. An illegal instruction gives illegal=1, wr_en=0 and result=0.
- R10: An instruction presented with in_valid=1 produces its outputs with out_valid=1 at the next clock edge. A cycle with in_valid=0 produces out_valid=0, wr_en=0, illegal=0 and result=0 at the next edge, whatever the other inputs hold.
- R11: While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 8 | Opcode byte: operation [7:4], operand select [3], class [2:0] |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Immediate field |
| out_valid | output | 1 | Registered result is present |
| result | output | 64 | Value for write-back |
| wr_en | output | 1 | Write-back strobe for a legal instruction |
| illegal | output | 1 | Instruction could not be executed |

## Verification
Every result, flag and out_valid is due exactly one clock after the instruction is presented. The bench drives each instruction on a falling edge and pushes the expected item into a queue. A monitor then compares the outputs on the next falling edge, half a period after the registering edge. A separate check presents one instruction followed by an idle cycle and requires out_valid to be high on exactly the following falling edge and low on the one after. This catches any extra or missing pipeline stage that the in-order queue alone would not detect.

// File: rtl/pf_alu_pkg.sv
`timescale 1ns/1ps
package pf_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_SUB  = 4'h1,
    OP_MUL  = 4'h2,
    OP_DIV  = 4'h3,
    OP_OR   = 4'h4,
    OP_AND  = 4'h5,
    OP_SHL  = 4'h6,
    OP_SHR  = 4'h7,
    OP_NEG  = 4'h8,
    OP_REM  = 4'h9,
    OP_XOR  = 4'ha,
    OP_MOVE = 4'hb,
    OP_SAR  = 4'hc,
    OP_BSWP = 4'hd
  } alu_op_e;

  localparam logic [2:0] CLS_NARROW = 3'h4;
  localparam logic [2:0] CLS_WIDE   = 3'h7;

  // byte-order width selector
  localparam logic [1:0] SW_16 = 2'd0;
  localparam logic [1:0] SW_32 = 2'd1;
  localparam logic [1:0] SW_64 = 2'd2;

  typedef struct packed {
    logic [3:0] op;
    logic       use_imm;
    logic       is64;
    logic       legal;
    logic [1:0] swap_sel;
  } dec_t;

endpackage

// File: rtl/pf_alu_decode.sv
`timescale 1ns/1ps
module pf_alu_decode
  import pf_alu_pkg::*;
#(
  parameter int IMM_W = 32
) (
  input  logic [7:0]       opcode,
  input  logic [IMM_W-1:0] imm,
  output dec_t             dec
);

  logic [2:0] cls;
  logic       cls_ok;
  logic       op_ok;
  logic       swap_ok;

  assign cls = opcode[2:0];
  assign cls_ok = (cls == CLS_NARROW) || (cls == CLS_WIDE);
  assign op_ok  = (opcode[7:4] <= OP_BSWP);

  always_comb begin
    swap_ok       = 1'b1;
    dec.swap_sel  = SW_64;
    if (imm == IMM_W'(16))      dec.swap_sel = SW_16;
    else if (imm == IMM_W'(32)) dec.swap_sel = SW_32;
    else if (imm == IMM_W'(64)) dec.swap_sel = SW_64;
    else                        swap_ok      = 1'b0;
  end

  assign dec.op      = opcode[7:4];
  assign dec.use_imm = opcode[3];
  assign dec.is64    = (cls == CLS_WIDE);
  assign dec.legal   = cls_ok && op_ok && ((opcode[7:4] != OP_BSWP) || swap_ok);

endmodule

// File: rtl/pf_alu_swap.sv
`timescale 1ns/1ps
module pf_alu_swap
  import pf_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] value,
  input  logic [1:0]        width_sel,
  input  logic              big,
  output logic [DATA_W-1:0] swapped
);

  localparam int N_W = 3;

  logic [DATA_W-1:0] cand [N_W];

  for (genvar g = 0; g < N_W; g++) begin : g_width
    localparam int NB = 2 << g;
    always_comb begin
      cand[g] = '0;
      for (int k = 0; k < NB; k++) begin
        if (big) cand[g][8*k +: 8] = value[8*(NB-1-k) +: 8];
        else     cand[g][8*k +: 8] = value[8*k +: 8];
      end
    end
  end

  always_comb begin
    case (width_sel)
      SW_16:   swapped = cand[0];
      SW_32:   swapped = cand[1];
      default: swapped = cand[2];
    endcase
  end

endmodule

// File: rtl/pf_alu_exec.sv
`timescale 1ns/1ps
module pf_alu_exec
  import pf_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input  logic [3:0]        op,
  input  logic              use_imm,
  input  logic              is64,
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] src,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] res,
  output logic              div_zero,
  output logic              rem_zero
);

  localparam int HALF_W = DATA_W / 2;
  localparam int N_LANE = 2;

  logic [DATA_W-1:0] lane_res [N_LANE];
  logic              lane_dz  [N_LANE];
  logic              lane_rz  [N_LANE];

  // lane 0 = 32-bit class, lane 1 = 64-bit class
  for (genvar L = 0; L < N_LANE; L++) begin : g_lane
    localparam int LW = (L == 0) ? HALF_W : DATA_W;
    localparam int SW = $clog2(LW);

    logic [LW-1:0] a;
    logic [LW-1:0] b;
    logic [SW-1:0] sh;
    logic [LW-1:0] r;
    logic          b_zero;

    assign a      = dst[LW-1:0];
    assign b      = use_imm ? LW'($signed(imm)) : src[LW-1:0];
    assign sh     = b[SW-1:0];
    assign b_zero = (b == '0);

    always_comb begin
      case (op)
        OP_ADD:  r = a + b;
        OP_SUB:  r = a - b;
        OP_MUL:  r = a * b;
        OP_DIV:  r = b_zero ? '0 : a / b;
        OP_OR:   r = a | b;
        OP_AND:  r = a & b;
        OP_SHL:  r = a << sh;
        OP_SHR:  r = a >> sh;
        OP_NEG:  r = '0 - a;
        OP_REM:  r = b_zero ? a : a % b;
        OP_XOR:  r = a ^ b;
        OP_MOVE: r = b;
        OP_SAR:  r = $signed(a) >>> sh;
        default: r = '0;
      endcase
    end

    assign lane_res[L] = DATA_W'(r);
    assign lane_dz[L]  = (op == OP_DIV) && b_zero;
    assign lane_rz[L]  = (op == OP_REM) && b_zero;
  end

  assign res      = is64 ? lane_res[1] : lane_res[0];
  assign div_zero = is64 ? lane_dz[1]  : lane_dz[0];
  assign rem_zero = is64 ? lane_rz[1]  : lane_rz[0];

endmodule

// File: rtl/pf_alu.sv
`timescale 1ns/1ps
module pf_alu
  import pf_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [IMM_W-1:0]  imm,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic              illegal
);

  dec_t              dec;
  logic [DATA_W-1:0] exec_res;
  logic [DATA_W-1:0] swap_res;
  logic [DATA_W-1:0] nxt_res;

  // named internal events for the checker
  logic ev_div_zero;
  logic ev_rem_zero;
  logic ev_illegal;
  logic ev_swap;

  pf_alu_decode #(.IMM_W(IMM_W)) u_dec (
    .opcode (opcode),
    .imm    (imm),
    .dec    (dec)
  );

  pf_alu_exec #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_exec (
    .op       (dec.op),
    .use_imm  (dec.use_imm),
    .is64     (dec.is64),
    .dst      (dst_val),
    .src      (src_val),
    .imm      (imm),
    .res      (exec_res),
    .div_zero (ev_div_zero),
    .rem_zero (ev_rem_zero)
  );

  pf_alu_swap #(.DATA_W(DATA_W)) u_swap (
    .value     (dst_val),
    .width_sel (dec.swap_sel),
    .big       (dec.use_imm),
    .swapped   (swap_res)
  );

  assign ev_illegal = in_valid && !dec.legal;
  assign ev_swap    = (dec.op == OP_BSWP);

  always_comb begin
    if (!in_valid || !dec.legal) nxt_res = '0;
    else if (ev_swap)            nxt_res = swap_res;
    else                         nxt_res = exec_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      wr_en     <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      result    <= nxt_res;
      wr_en     <= in_valid && dec.legal;
      illegal   <= ev_illegal;
    end
  end

endmodule

// File: rtl/pf_alu_chk.sv
`timescale 1ns/1ps
module pf_alu_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [7:0]        opcode,
  input logic [DATA_W-1:0] dst_val,
  input logic [DATA_W-1:0] src_val,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              wr_en,
  input logic              illegal,
  input logic              ev_div_zero
);

  localparam int HALF_W = DATA_W / 2;

  logic cls_bad;
  assign cls_bad = (opcode[2:0] != 3'h4) && (opcode[2:0] != 3'h7);

  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && illegal));

  p_bad_class_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls_bad) |=> (illegal && !wr_en && result == '0));

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !wr_en && !illegal && result == '0));

  p_zext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode[2:0] == 3'h4 && opcode[7:4] < 4'hd)
      |=> (result[DATA_W-1:HALF_W] == '0));

  p_div_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_div_zero && !cls_bad) |=> (wr_en && result == '0));

  p_rem_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 8'h97 && src_val == '0) |=> (result == $past(dst_val)));

  p_neg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 8'h87) |=> (result == '0 - $past(dst_val)));

endmodule

bind pf_alu pf_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .opcode      (opcode),
  .dst_val     (dst_val),
  .src_val     (src_val),
  .out_valid   (out_valid),
  .result      (result),
  .wr_en       (wr_en),
  .illegal     (illegal),
  .ev_div_zero (ev_div_zero)
);

// File: tb/pf_alu_tb_top.sv
`timescale 1ns/1ps
module pf_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  opcode = '0;
  logic [63:0] dst_val = '0;
  logic [63:0] src_val = '0;
  logic [31:0] imm = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        wr_en;
  logic        illegal;

  always #2.5 clk = ~clk;

  pf_alu dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .dst_val   (dst_val),
    .src_val   (src_val),
    .imm       (imm),
    .out_valid (out_valid),
    .result    (result),
    .wr_en     (wr_en),
    .illegal   (illegal)
  );

  typedef struct {
    logic [63:0] res;
    logic        we;
    logic        ill;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  function automatic exp_t model(input logic [7:0] op8, input logic [63:0] d,
                                 input logic [63:0] s, input logic [31:0] i);
    exp_t        e;
    logic [3:0]  code;
    logic        wide;
    logic [63:0] A;
    logic [63:0] B;
    logic [5:0]  sh;
    logic [63:0] r;
    logic signed [31:0] t32;
    int          nb;
    code = op8[7:4];
    wide = (op8[2:0] == 3'h7);
    e.tag = "";
    nb = (i == 32'd16) ? 2 : (i == 32'd32) ? 4 : (i == 32'd64) ? 8 : 0;
    if (!((op8[2:0] == 3'h4) || wide) || code > 4'hd || (code == 4'hd && nb == 0)) begin
      e.res = '0; e.we = 1'b0; e.ill = 1'b1;
      return e;
    end
    e.we = 1'b1; e.ill = 1'b0;
    if (code == 4'hd) begin
      r = '0;
      if (op8[3]) begin
        for (int k = 0; k < nb; k++) r = (r << 8) | {56'b0, d[8*k +: 8]};
      end else begin
        r = (nb == 8) ? d : (d & ((64'd1 << (8*nb)) - 64'd1));
      end
      e.res = r;
      return e;
    end
    A = wide ? d : {32'b0, d[31:0]};
    if (op8[3]) B = wide ? {{32{i[31]}}, i} : {32'b0, i};
    else        B = wide ? s : {32'b0, s[31:0]};
    sh = wide ? B[5:0] : {1'b0, B[4:0]};
    case (code)
      4'h0: r = A + B;
      4'h1: r = A - B;
      4'h2: r = A * B;
      4'h3: r = (B == 0) ? 64'd0 : A / B;
      4'h4: r = A | B;
      4'h5: r = A & B;
      4'h6: r = A << sh;
      4'h7: r = A >> sh;
      4'h8: r = 64'd0 - A;
      4'h9: r = (B == 0) ? A : A % B;
      4'ha: r = A ^ B;
      4'hb: r = B;
      default: begin
        if (wide) r = $signed(A) >>> sh;
        else begin
          t32 = A[31:0];
          t32 = t32 >>> sh;
          r = {32'b0, t32};
        end
      end
    endcase
    if (!wide) r = r & 64'h0000_0000_FFFF_FFFF;
    e.res = r;
    return e;
  endfunction

  task automatic check(input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, expv);
    end
  endtask

  task automatic send(input logic [7:0] op8, input logic [63:0] d,
                      input logic [63:0] s, input logic [31:0] i, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; opcode = op8; dst_val = d; src_val = s; imm = i;
    e = model(op8, d, s, i);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 1'b0; opcode = 8'hFF; dst_val = 64'hDEAD_BEEF_0BAD_F00D;
    src_val = 64'h1234; imm = 32'h40;
  endtask

  // monitor: scoreboard pop and compare, one cycle after issue
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R10 unexpected out_valid", {63'b0, out_valid}, 64'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(result === e.res && wr_en === e.we && illegal === e.ill,
              e.tag, {result[61:0], wr_en, illegal}, {e.res[61:0], e.we, e.ill});
      end
    end
  end

  localparam logic [63:0] BV = 64'h1122_3344_5566_7788;

  initial begin
    repeat (3) @(negedge clk);
    in_valid = 1'b1; opcode = 8'h07; dst_val = 64'd5; src_val = 64'd6;
    @(negedge clk);
    // R11: outputs held at zero during reset
    check(out_valid === 1'b0 && result === '0 && wr_en === 1'b0 && illegal === 1'b0,
          "R11 reset state", result, 64'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && result === '0, "R11 after reset", result, 64'd0);

    // R1 64-bit register-source ops
    send(8'h07, 64'h0000_0001_FFFF_FFFF, 64'd1, 32'd0, "R1 add64 reg");
    send(8'h17, 64'd3, 64'd5, 32'd0, "R1 sub64 wrap");
    send(8'h47, 64'hF0F0_0000_0000_00F0, 64'h0F00_0000_0000_000F, 32'd0, "R1 or64");
    send(8'h57, 64'hFFFF_0000_FFFF_0000, 64'h0FF0_0FF0_0FF0_0FF0, 32'd0, "R1 and64");
    send(8'ha7, 64'hAAAA_AAAA_5555_5555, 64'hFFFF_FFFF_FFFF_FFFF, 32'd0, "R1 xor64");
    send(8'hb7, 64'd99, 64'h8000_0000_0000_0001, 32'd0, "R1 mov64 reg");
    // R2 immediate select and sign extension
    send(8'h1F, 64'd5, 64'd1000, 32'hFFFF_FFFF, "R2 sub64 imm -1");
    send(8'hbF, 64'd0, 64'd7, 32'h8000_0000, "R2 mov64 imm signext");
    send(8'h0F, 64'd10, 64'hFFFF, 32'd7, "R2 add64 imm");
    // R3 32-bit class
    send(8'h04, 64'h0000_0001_FFFF_FFFF, 64'd1, 32'd0, "R3 add32 wrap");
    send(8'h0C, 64'hAAAA_0000_0000_0005, 64'd0, 32'hFFFF_FFFF, "R3 add32 imm");
    send(8'hbC, 64'd0, 64'd0, 32'h8000_0000, "R3 mov32 imm no signext");
    send(8'h14, 64'd0, 64'd1, 32'd0, "R3 sub32 underflow");
    // R4 shifts
    send(8'h67, 64'd1, 64'd65, 32'd0, "R4 shl64 mask6");
    send(8'h64, 64'd1, 64'd33, 32'd0, "R4 shl32 mask5");
    send(8'h64, 64'h0000_0000_8000_0001, 64'd1, 32'd0, "R4 shl32 drop top");
    send(8'h77, 64'h8000_0000_0000_0000, 64'd63, 32'd0, "R4 shr64");
    send(8'h74, 64'hFFFF_FFFF_8000_0000, 64'd4, 32'd0, "R4 shr32");
    send(8'hc4, 64'h0000_0000_8000_0000, 64'd4, 32'd0, "R4 sar32");
    send(8'hc7, 64'h8000_0000_0000_0000, 64'd4, 32'd0, "R4 sar64");
    send(8'hcF, 64'h7000_0000_0000_0000, 64'd0, 32'd66, "R4 sar64 imm mask");
    // R5 multiply
    send(8'h27, 64'h0000_0001_0000_0001, 64'h0000_0001_0000_0003, 32'd0, "R5 mul64");
    send(8'h24, 64'h0000_0000_FFFF_FFFF, 64'd2, 32'd0, "R5 mul32");
    // R6 divide and remainder
    send(8'h37, 64'd100, 64'd7, 32'd0, "R6 div64");
    send(8'h34, 64'h0000_0000_FFFF_FFFE, 64'd2, 32'd0, "R6 div32 unsigned");
    send(8'h37, 64'd100, 64'd0, 32'd0, "R6 div64 by zero");
    send(8'h97, 64'd100, 64'd7, 32'd0, "R6 rem64");
    send(8'h97, 64'h1234_5678_9ABC_DEF0, 64'd0, 32'd0, "R6 rem64 by zero");
    send(8'h94, 64'h1234_5678_9ABC_DEF0, 64'h1_0000_0000, 32'd0, "R6 rem32 by zero");
    send(8'h3C, 64'd9, 64'd0, 32'd0, "R6 div32 imm zero");
    // R7 negate
    send(8'h87, 64'd1, 64'd0, 32'd0, "R7 neg64");
    send(8'h84, 64'd1, 64'd0, 32'd0, "R7 neg32");
    // R8 byte order
    send(8'hdC, BV, 64'd0, 32'd16, "R8 big16");
    send(8'hdC, BV, 64'd0, 32'd32, "R8 big32");
    send(8'hdF, BV, 64'd0, 32'd64, "R8 big64");
    send(8'hd4, BV, 64'd0, 32'd16, "R8 little16");
    send(8'hd7, BV, 64'd0, 32'd64, "R8 little64");
    // R9 illegal encodings
    send(8'he7, 64'd1, 64'd1, 32'd0, "R9 op e");
    send(8'hf4, 64'd1, 64'd1, 32'd0, "R9 op f");
    send(8'h00, 64'd1, 64'd1, 32'd0, "R9 class 0");
    send(8'h05, 64'd1, 64'd1, 32'd0, "R9 class 5");
    send(8'h06, 64'd1, 64'd1, 32'd0, "R9 class 6");
    send(8'hdC, BV, 64'd0, 32'd8, "R9 byte order bad width");
    go_idle();
    repeat (3) @(negedge clk);
    // R10: idle cycles with garbage inputs give nothing
    check(out_valid === 1'b0 && wr_en === 1'b0 && illegal === 1'b0 && result === '0,
          "R10 idle outputs", result, 64'd0);
    // R10 latency: single issue, valid exactly one edge later
    send(8'h07, 64'd2, 64'd3, 32'd0, "R10 single add");
    go_idle();
    check(out_valid === 1'b1, "R10 one-cycle latency", {63'b0, out_valid}, 64'd1);
    @(negedge clk);
    check(out_valid === 1'b0, "R10 valid drops", {63'b0, out_valid}, 64'd0);
    repeat (2) @(negedge clk);
    check(q.size() == 0, "R10 scoreboard drained", 64'(q.size()), 64'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule